// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the cycle decoder, burst address generator and data-path control of a flow-through synchronous burst SRAM. The memory has a common data bus and a word of two byte lanes. On every rising clock edge it samples three chip enables, two address strobes, an advance input and the write controls. From these it decides whether the cycle deselects the device, starts a new access, advances a burst or suspends a burst. It then writes the chosen byte lanes into the array, or presents read data and enables the output driver.

The two strobes follow different rules. The processor strobe only counts while the main enable is low, and it always starts a read. The controller strobe can start a read or a write and can restart a burst that is in progress. After a start, the advance input moves a 2-bit burst counter in linear or interleaved order. Read data flows through from the array at the address registered on the edge, with no output register. The output-drive signal combines the registered cycle type with an asynchronous output-enable input.

Top module: `sbsram_ctrl`

## Requirements
- R1: After reset, and until a strobe starts an access, `dout_en` stays low and a cycle with no strobe writes nothing.
- R2: A strobe that starts an access selects the device only when `en_main_n`=0, `en_exp_hi`=1 and `en_exp_n`=0. Any other combination deselects the device: it writes nothing, and `dout_en` stays low on that cycle and on the following cycles with no strobe.
- R3: `cpu_strobe_n` low while `en_main_n` is high is ignored. With `ctl_strobe_n` high, the cycle continues or suspends the current burst.
- R4: A processor-strobe start is always a read. All write controls are ignored in that cycle.
- R5: `wr_all_n`=0 on a write-capable cycle writes both lanes, whatever `wr_byte_n` and `lane_wr_n` are.
- R6: With `wr_all_n`=1 and `wr_byte_n`=1 the cycle is a read. With `wr_byte_n`=0, `lane_wr_n[0]`=0 writes bits [8:0] and `lane_wr_n[1]`=0 writes bits [17:9]. Both high is a read.
- R7: In the cycle after an edge that sampled a write, `dout_en` is low even when `oe_n` is low.
- R8: Read data is flow-through. After the edge that registers a read address, `dout` shows the word at that address in the same cycle.
- R9: Advance (`step_n`=0) steps the low 2 address bits. With `burst_interleave`=0 the offset is (start+k) mod 4. With `burst_interleave`=1 it is start XOR k. The mode is latched at the start, the upper bits are fixed, and the sequence wraps after four words.
- R10: `step_n`=1 on a continue cycle holds the burst address. A controller-strobe start loads a new address and may write in that same cycle.
- R11: `dout_en` is high exactly when the registered cycle is a selected read and `oe_n` is low. `oe_n` acts without waiting for a clock edge.
- R12: If both strobes are low while `en_main_n` is low, the processor strobe wins and the cycle is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_main_n | input | 1 | Main chip enable, active low; also gates the processor strobe |
| en_exp_hi | input | 1 | Expansion enable, active high |
| en_exp_n | input | 1 | Expansion enable, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| burst_interleave | input | 1 | 1 = interleaved order, 0 = linear order, latched at a start |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | 2 | Per-lane write selects, active low; bit 0 = lane [8:0] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address sampled on a start |
| din | input | 18 | Write data |
| dout | output | 18 | Flow-through read data |
| dout_en | output | 1 | Output driver enable (low = high impedance) |

## Verification
The hardest case to reach is a processor-strobe start whose write controls are fully asserted and whose address is the one the following advance cycles will write. Proving this needs a later readback to show the first cycle wrote nothing. The same applies to a burst continued through an ignored processor strobe while the main enable is high. Directed sequences prefill every address with a distinct pattern and then build these cases on purpose. A long seeded random run follows, biased toward the strobes and global write. It produces mixed bursts, suspends, deselects and lane writes, and a bench model checks every cycle, including the output-enable toggle between edges.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Decoded kind of the cycle sampled on a rising edge
  typedef enum logic [2:0] {
    CYC_IDLE    = 3'd0,  // no strobe while deselected
    CYC_DESEL   = 3'd1,  // start with bad enables
    CYC_START_P = 3'd2,  // processor-strobe start (read only)
    CYC_START_C = 3'd3,  // controller-strobe start
    CYC_NEXT    = 3'd4,  // continue burst, advance
    CYC_HOLD    = 3'd5   // continue burst, suspend
  } cyc_kind_t;

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             en_main_n,
  input  logic             en_exp_hi,
  input  logic             en_exp_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             active_q,
  output cyc_kind_t        kind,
  output logic [LANES-1:0] wr_mask
);

  logic             sel_ok;
  logic [LANES-1:0] req_mask;
  logic             wr_capable;

  assign sel_ok = ~en_main_n & en_exp_hi & ~en_exp_n;

  // Lane request: global write overrides, byte enable gates lane selects
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_req
      assign req_mask[g] = ~wr_all_n | (~wr_byte_n & ~lane_wr_n[g]);
    end
  endgenerate

  always_comb begin
    if (!cpu_strobe_n && !en_main_n) begin
      kind = sel_ok ? CYC_START_P : CYC_DESEL;
    end else if (!ctl_strobe_n) begin
      kind = sel_ok ? CYC_START_C : CYC_DESEL;
    end else if (!active_q) begin
      kind = CYC_IDLE;
    end else begin
      kind = step_n ? CYC_HOLD : CYC_NEXT;
    end
  end

  assign wr_capable = (kind == CYC_START_C) || (kind == CYC_NEXT) || (kind == CYC_HOLD);
  assign wr_mask    = wr_capable ? req_mask : '0;

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  cyc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] eff_addr
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] cnt_q;
  logic               mode_q;
  logic               start;

  function automatic logic [BURST_W-1:0] offset(
    input logic [BURST_W-1:0] b,
    input logic [BURST_W-1:0] c,
    input logic               il
  );
    return il ? (b ^ c) : (b + c);
  endfunction

  assign start    = (kind == CYC_START_P) || (kind == CYC_START_C);
  assign cur_addr = {hi_q, offset(base_q, cnt_q, mode_q)};

  always_comb begin
    if (start)                 eff_addr = addr_in;
    else if (kind == CYC_NEXT) eff_addr = {hi_q, offset(base_q, cnt_q + 1'b1, mode_q)};
    else                       eff_addr = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      hi_q   <= addr_in[ADDR_W-1:BURST_W];
      base_q <= addr_in[BURST_W-1:0];
      cnt_q  <= '0;
      mode_q <= interleave;
    end else if (kind == CYC_NEXT) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_HOLD) |=> (cur_addr == $past(cur_addr)));

  // R9
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_NEXT) |=> (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W])));

  // R8
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cur_addr == $past(addr_in)));

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANE_W*LANES-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANE_W*LANES-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
        if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
  endgenerate

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_main_n,
  input  logic                    en_exp_hi,
  input  logic                    en_exp_n,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    step_n,
  input  logic                    burst_interleave,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANE_W*LANES-1:0] din,
  output logic [LANE_W*LANES-1:0] dout,
  output logic                    dout_en
);

  localparam int WORD_W = LANE_W * LANES;

  cyc_kind_t         kind;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [WORD_W-1:0] rdata;
  logic              active_q;
  logic              rd_q;
  logic              is_access;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .en_main_n    (en_main_n),
    .en_exp_hi    (en_exp_hi),
    .en_exp_n     (en_exp_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_n    (wr_byte_n),
    .lane_wr_n    (lane_wr_n),
    .active_q     (active_q),
    .kind         (kind),
    .wr_mask      (wr_mask)
  );

  sbsram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .kind       (kind),
    .addr_in    (addr),
    .interleave (burst_interleave),
    .cur_addr   (cur_addr),
    .eff_addr   (eff_addr)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .we    (wr_mask),
    .waddr (eff_addr),
    .wdata (din),
    .raddr (cur_addr),
    .rdata (rdata)
  );

  assign is_access = (kind == CYC_START_P) || (kind == CYC_START_C) ||
                     (kind == CYC_NEXT)    || (kind == CYC_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      if (kind == CYC_START_P || kind == CYC_START_C) active_q <= 1'b1;
      else if (kind == CYC_DESEL)                     active_q <= 1'b0;
      rd_q <= is_access && (wr_mask == '0);
    end
  end

  assign dout    = rdata;
  assign dout_en = rd_q & ~oe_n;

  // R7
  write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mask != '0) |=> !dout_en);

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_DESEL) |=> !dout_en);

  // R4
  cpu_start_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_strobe_n && !en_main_n) |-> (wr_mask == '0));

  // R5
  global_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_all_n && (kind == CYC_START_C || kind == CYC_NEXT || kind == CYC_HOLD)) |-> (&wr_mask));

  // R1
  idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_IDLE) |-> (wr_mask == '0));

endmodule

// File: tb/sbsram_ctrl_bench.sv
`timescale 1ns/1ps
module sbsram_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs1_n, cs2, cs3_n, ps_n, cs_n, adv_n, mode, gw_n, bwe_n, oe_n;
  logic [1:0]  bw_n;
  logic [9:0]  a;
  logic [17:0] d;
  logic [17:0] q;
  logic        qen;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sbsram_ctrl u_sbsram_ctrl (
    .clk(clk), .rst(rst), .en_main_n(cs1_n), .en_exp_hi(cs2), .en_exp_n(cs3_n),
    .cpu_strobe_n(ps_n), .ctl_strobe_n(cs_n), .step_n(adv_n), .burst_interleave(mode),
    .wr_all_n(gw_n), .wr_byte_n(bwe_n), .lane_wr_n(bw_n), .oe_n(oe_n),
    .addr(a), .din(d), .dout(q), .dout_en(qen)
  );

  // Bench model state
  logic [17:0] mem_m [1024];
  logic        m_active = 1'b0;
  logic        m_rd     = 1'b0;
  logic [7:0]  m_hi     = '0;
  logic [1:0]  m_base   = '0;
  logic [1:0]  m_cnt    = '0;
  logic        m_mode   = 1'b0;

  function automatic logic [1:0] ofs(input logic [1:0] b, input logic [1:0] c, input logic il);
    return il ? (b ^ c) : (b + c);
  endfunction

  function automatic logic [9:0] m_cur();
    return {m_hi, ofs(m_base, m_cnt, m_mode)};
  endfunction

  function automatic logic [17:0] pat(input int k);
    logic [8:0] h, l;
    h = 9'(k * 7 + 64);
    l = 9'(k * 11 + 3);
    return {h, l};
  endfunction

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model of one edge, from the requirements; kinds: 0 idle 1 desel 2 cpu 3 ctl 4 next 5 hold
  task automatic model_step(output string tag);
    logic       sel_ok;
    logic [1:0] req, wm;
    logic [9:0] ea;
    int         k;
    sel_ok = !cs1_n && cs2 && !cs3_n;
    req = !gw_n ? 2'b11 : (bwe_n ? 2'b00 : ~bw_n);
    if (!ps_n && !cs1_n) begin
      k = sel_ok ? 2 : 1;
      tag = sel_ok ? (!cs_n ? "R12" : "R4") : "R2";
    end else if (!cs_n) begin
      k = sel_ok ? 3 : 1;
      tag = sel_ok ? "R8" : "R2";
    end else if (!m_active) begin
      k = 0; tag = "R1";
    end else begin
      k = adv_n ? 5 : 4;
      tag = !ps_n ? "R3" : (adv_n ? "R10" : "R9");
    end
    if (k == 2 || k == 3) ea = a;
    else if (k == 4)      ea = {m_hi, ofs(m_base, m_cnt + 2'd1, m_mode)};
    else                  ea = m_cur();
    wm = (k >= 3) ? req : 2'b00;
    if (wm[0]) mem_m[ea][8:0]  = d[8:0];
    if (wm[1]) mem_m[ea][17:9] = d[17:9];
    if (wm != 2'b00) tag = "R7";
    if (k == 2 || k == 3) begin
      m_active = 1'b1; m_hi = a[9:2]; m_base = a[1:0]; m_cnt = 2'd0; m_mode = mode;
    end else if (k == 1) begin
      m_active = 1'b0;
    end else if (k == 4) begin
      m_cnt = m_cnt + 2'd1;
    end
    m_rd = (k >= 2) && (wm == 2'b00);
  endtask

  // One clock cycle with the inputs as currently driven, checked against the model
  task automatic cyc();
    string tag;
    logic  exp_en;
    @(posedge clk);
    model_step(tag);
    #5;
    exp_en = m_rd && !oe_n;
    chk(tag, {17'd0, qen}, {17'd0, exp_en});
    if (exp_en) chk(tag, q, mem_m[m_cur()]);
    oe_n = ~oe_n;
    #1;
    chk("R11", {17'd0, qen}, {17'd0, m_rd && !oe_n});
    oe_n = ~oe_n;
    #1;
  endtask

  task automatic quiet();
    cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; ps_n = 1'b1; cs_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11; oe_n = 1'b0; d = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1: watchdog expired, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1297));
    quiet(); mode = 1'b0; a = '0;
    repeat (3) @(posedge clk);
    #7;
    chk("R1", {17'd0, qen}, 18'd0);
    rst = 1'b0;
    // R1: continue request with no burst started
    adv_n = 1'b0; cyc();
    chk("R1", {17'd0, qen}, 18'd0);
    quiet();

    // Prefill 0..15 with controller-strobe global writes (R5)
    for (int k = 0; k < 16; k++) begin
      cs_n = 1'b0; gw_n = 1'b0; a = 10'(k); d = pat(k); cyc();
      chk("R7", {17'd0, qen}, 18'd0);
    end
    quiet();

    // R4: processor start with every write control asserted is a read
    ps_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b00; a = 10'd5; d = 18'h3FFFF; cyc();
    chk("R4", q, pat(5));
    chk("R4", {17'd0, qen}, 18'd1);
    quiet(); cs_n = 1'b0; a = 10'd5; cyc();
    chk("R4", q, pat(5));

    // R12: both strobes, processor wins
    quiet(); ps_n = 1'b0; cs_n = 1'b0; gw_n = 1'b0; a = 10'd6; d = 18'h0; cyc();
    chk("R12", q, pat(6));

    // R9: linear burst from 2 wraps 3,0,1,2
    quiet(); ps_n = 1'b0; mode = 1'b0; a = 10'd2; cyc();
    chk("R9", q, pat(2));
    quiet(); adv_n = 1'b0; mode = 1'b1;
    cyc(); chk("R9", q, pat(3));
    cyc(); chk("R9", q, pat(0));
    cyc(); chk("R9", q, pat(1));
    cyc(); chk("R9", q, pat(2));

    // R9: interleaved burst from 9 gives 8,11,10,9
    quiet(); ps_n = 1'b0; mode = 1'b1; a = 10'd9; cyc();
    quiet(); adv_n = 1'b0; mode = 1'b0;
    cyc(); chk("R9", q, pat(8));
    cyc(); chk("R9", q, pat(11));
    cyc(); chk("R9", q, pat(10));
    cyc(); chk("R9", q, pat(9));

    // R10: suspend holds the address
    quiet(); cs_n = 1'b0; a = 10'd4; cyc();
    quiet(); cyc(); chk("R10", q, pat(4));
    cyc(); chk("R10", q, pat(4));

    // R3: processor strobe with main enable high continues the burst
    quiet(); ps_n = 1'b0; a = 10'd12; cyc();
    quiet(); ps_n = 1'b0; cs1_n = 1'b1; adv_n = 1'b0; a = 10'd0; cyc();
    chk("R3", q, pat(13));
    chk("R3", {17'd0, qen}, 18'd1);

    // R6: lane [8:0] only
    quiet(); cs_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b10; a = 10'd3; d = 18'h3FFFF; cyc();
    quiet(); cs_n = 1'b0; a = 10'd3; cyc();
    chk("R6", q, {pat(3)[17:9], 9'h1FF});
    // R6: lane [17:9] only
    quiet(); cs_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b01; a = 10'd14; d = 18'h00000; cyc();
    quiet(); cs_n = 1'b0; a = 10'd14; cyc();
    chk("R6", q, {9'h000, pat(14)[8:0]});
    // R6: byte enable high with lanes low is a read
    quiet(); cs_n = 1'b0; bw_n = 2'b00; a = 10'd7; d = 18'h3FFFF; cyc();
    chk("R6", {17'd0, qen}, 18'd1);
    chk("R6", q, pat(7));

    // R5: global write overrides byte controls; R7 bus released with oe low
    quiet(); cs_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b1; bw_n = 2'b11; a = 10'd8; d = 18'h15555; cyc();
    chk("R7", {17'd0, qen}, 18'd0);
    quiet(); cs_n = 1'b0; a = 10'd8; cyc();
    chk("R5", q, 18'h15555);

    // R10: controller start writes, burst write continues on advance
    quiet(); cs_n = 1'b0; gw_n = 1'b0; a = 10'd0; d = 18'h0AAAA; cyc();
    quiet(); adv_n = 1'b0; gw_n = 1'b0; d = 18'h0BBBB; cyc();
    quiet(); cs_n = 1'b0; a = 10'd1; cyc();
    chk("R10", q, 18'h0BBBB);

    // R2: bad expansion enable deselects and blocks the write
    quiet(); cs_n = 1'b0; cs2 = 1'b0; gw_n = 1'b0; a = 10'd1; d = 18'h3C3C3; cyc();
    chk("R2", {17'd0, qen}, 18'd0);
    quiet(); adv_n = 1'b0; cyc();
    chk("R2", {17'd0, qen}, 18'd0);
    quiet(); cs_n = 1'b0; a = 10'd1; cyc();
    chk("R2", q, 18'h0BBBB);

    // R8: flow-through read in the cycle after the address edge
    quiet(); cs_n = 1'b0; a = 10'd10; cyc();
    chk("R8", q, pat(10));

    // Seeded random traffic on addresses 0..15
    for (int i = 0; i < 4000; i++) begin
      cs1_n = ($urandom % 8) == 0;
      cs2   = ($urandom % 8) != 0;
      cs3_n = ($urandom % 8) == 0;
      ps_n  = ($urandom % 5) != 0;
      cs_n  = ($urandom % 5) != 0;
      adv_n = $urandom % 2;
      mode  = $urandom % 2;
      gw_n  = ($urandom % 6) != 0;
      bwe_n = $urandom % 2;
      bw_n  = 2'($urandom);
      oe_n  = ($urandom % 4) == 0;
      a     = 10'($urandom % 16);
      d     = 18'($urandom);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule